// File: doc/BRIEF.md
# Relocatable Legacy I/O Function Decoder

This block holds the configuration registers of a south-bridge legacy I/O complex. It also decodes each incoming legacy port access into a select line for one of four sub-functions: a floppy controller, a parallel port and two serial ports. Software reaches the registers through a two-byte window. The low byte of the window latches a register index. The byte just above it reads or writes the register that the index names.

Some of these registers switch the functions on and off. Others place each function's 8-byte decode window anywhere in I/O space. Each function forms its base address from its register with its own masking and shift. Every access is decoded in the cycle it is presented: `io_valid` qualifies `io_addr`, and the selects and `io_rdata` are combinational.

The block has no back-pressure. An access is taken in every cycle that `io_valid` is high, and each write takes effect at that clock edge. The decode of the next access already uses the new value.

Top module: `legacy_io_router`

## Requirements
- R1: Port 0x3F0 is the index port and 0x3F1 is the data port. Writing 0x3F0 latches the index, and reading 0x3F0 returns the last index written. Any valid access to either port asserts `sel_cfg` and no function select.
- R2: A read of 0x3F1 returns the register named by the index. Reading an index that has no register returns 0x00. `io_rdata` is 0x00 whenever no read of either config port is presented.
- R3: After reset the registers hold these values: 0xE0=0x3C (device ID), 0xE2=0x0F, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Serial 1 decodes at 0x3F8 and serial 2 at 0x2F8, while the floppy and parallel functions are off.
- R4: Register 0xE2 holds the enables. Bit 2 enables serial 1, bit 3 enables serial 2 and bit 4 enables the floppy. A disabled function never asserts its select.
- R5: Bits [1:0] of 0xE2 are the parallel mode. The parallel port is disabled only when the mode is 3. Modes 0, 1 and 2 enable it.
- R6: The floppy base is (0xE3 AND 0xFC) shifted left by 2.
- R7: The parallel base is all eight bits of 0xE6 shifted left by 2. Its window covers base to base+7, even when the base is not 8-aligned.
- R8: The serial 1 base is (0xE7 AND 0xFE) shifted left by 2. The serial 2 base is formed from 0xE8 by the same rule.
- R9: Data writes to index 0xE0, to indices 0xFD to 0xFF, and to any index without a writable register change no register.
- R10: A data write to an enable or base register changes the decode for the access presented in the very next cycle.
- R11: Each function window spans 8 bytes. At most one select is asserted at a time, and none while `io_valid` is low. When windows overlap, the order of precedence is the config pair, then serial 1, then serial 2, then parallel, then floppy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | An I/O access is presented this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W (16) | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Config read data (0 when no config read is presented) |
| sel_cfg | output | 1 | Access claimed by the config index/data pair |
| sel_sp1 | output | 1 | Access routed to serial port 1 |
| sel_sp2 | output | 1 | Access routed to serial port 2 |
| sel_lpt | output | 1 | Access routed to the parallel port |
| sel_fdc | output | 1 | Access routed to the floppy controller |

## Verification
The floppy window at 0x3F0 covers the config pair. The bench shows that 0x3F0 and 0x3F1 stay with the config logic while 0x3F4 reaches the floppy; a decoder that ranked these the wrong way would lose register access once the floppy was on. The parallel window is placed at 0x3BC, which is not 8-aligned, and its edges are probed. A decoder that compared only the upper address bits would miss 0x3C0 to 0x3C3 and wrongly claim 0x3B8. All four parallel modes are tried, along with writes carrying odd values to the masked base registers. A design that tested a single enable bit, or that kept the base bits that should be cleared, would move a window or leave the port on in the wrong mode. Overlapping serial and parallel windows, writes to read-only and unmapped indices, and a decode in the cycle right after a write cover the precedence order and the immediate effect of writes.

// File: rtl/lio_pkg.sv
package lio_pkg;
  localparam int NUM_FN = 4;

  // function slots, listed in decode precedence order
  typedef enum logic [1:0] {
    FN_SP1 = 2'd0,
    FN_SP2 = 2'd1,
    FN_LPT = 2'd2,
    FN_FDC = 2'd3
  } fn_e;

  typedef struct packed {
    logic [7:0] fsel;
    logic [7:0] fdc_base;
    logic [7:0] lpt_base;
    logic [7:0] sp1_base;
    logic [7:0] sp2_base;
  } cfg_regs_t;

  localparam logic [7:0] IDX_DEVID = 8'hE0;
  localparam logic [7:0] IDX_FSEL  = 8'hE2;
  localparam logic [7:0] IDX_FDC   = 8'hE3;
  localparam logic [7:0] IDX_LPT   = 8'hE6;
  localparam logic [7:0] IDX_SP1   = 8'hE7;
  localparam logic [7:0] IDX_SP2   = 8'hE8;

  localparam logic [7:0] DEVID_VAL = 8'h3C;

  localparam cfg_regs_t CFG_RESET = '{
    fsel:     8'h0F,
    fdc_base: 8'hFC,
    lpt_base: 8'hDE,
    sp1_base: 8'hFE,
    sp2_base: 8'hBE
  };
endpackage

// File: rtl/lio_cfg_regs.sv
module lio_cfg_regs
  import lio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        index_q,
  output cfg_regs_t         regs_q,
  output logic [7:0]        rdata,
  output logic              cfg_hit
);
  localparam logic [ADDR_W-1:0] DATA_PORT = CFG_PORT + 1'b1;

  logic idx_sel, dat_sel;
  logic [7:0] reg_view;

  assign idx_sel = io_valid && (io_addr == CFG_PORT);
  assign dat_sel = io_valid && (io_addr == DATA_PORT);
  assign cfg_hit = idx_sel || dat_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      regs_q  <= CFG_RESET;
    end else begin
      if (idx_sel && io_write) begin
        index_q <= io_wdata;
      end
      if (dat_sel && io_write) begin
        case (index_q)
          IDX_FSEL: regs_q.fsel     <= io_wdata;
          IDX_FDC:  regs_q.fdc_base <= io_wdata;
          IDX_LPT:  regs_q.lpt_base <= io_wdata;
          IDX_SP1:  regs_q.sp1_base <= io_wdata;
          IDX_SP2:  regs_q.sp2_base <= io_wdata;
          default:  ; // device ID, read-only and unmapped indices
        endcase
      end
    end
  end

  always_comb begin
    case (index_q)
      IDX_DEVID: reg_view = DEVID_VAL;
      IDX_FSEL:  reg_view = regs_q.fsel;
      IDX_FDC:   reg_view = regs_q.fdc_base;
      IDX_LPT:   reg_view = regs_q.lpt_base;
      IDX_SP1:   reg_view = regs_q.sp1_base;
      IDX_SP2:   reg_view = regs_q.sp2_base;
      default:   reg_view = 8'h00;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (!io_write) begin
      if (idx_sel)      rdata = index_q;
      else if (dat_sel) rdata = reg_view;
    end
  end
endmodule

// File: rtl/lio_base_map.sv
module lio_base_map
  import lio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  cfg_regs_t         regs,
  output logic [ADDR_W-1:0] base [NUM_FN],
  output logic [NUM_FN-1:0] en
);
  // each function forms its base with its own mask, then shifts left by 2
  assign base[FN_SP1] = ADDR_W'({regs.sp1_base[7:1], 1'b0, 2'b00});
  assign base[FN_SP2] = ADDR_W'({regs.sp2_base[7:1], 1'b0, 2'b00});
  assign base[FN_LPT] = ADDR_W'({regs.lpt_base, 2'b00});
  assign base[FN_FDC] = ADDR_W'({regs.fdc_base[7:2], 2'b00, 2'b00});

  assign en[FN_SP1] = regs.fsel[2];
  assign en[FN_SP2] = regs.fsel[3];
  assign en[FN_LPT] = (regs.fsel[1:0] != 2'b11);
  assign en[FN_FDC] = regs.fsel[4];
endmodule

// File: rtl/lio_window.sv
module lio_window #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 8
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] offset;

  // offset compare handles bases that are not window-aligned
  assign offset = addr - base;
  assign hit    = enable && (offset < SPAN);
endmodule

// File: rtl/lio_prio.sv
module lio_prio #(
  parameter int N = 4
) (
  input  logic         block,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = block;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/legacy_io_router.sv
module legacy_io_router
  import lio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 8,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              sel_cfg,
  output logic              sel_sp1,
  output logic              sel_sp2,
  output logic              sel_lpt,
  output logic              sel_fdc
);
  logic [7:0]        index_q;
  cfg_regs_t         regs_q;
  logic              cfg_hit;
  logic [ADDR_W-1:0] fn_base [NUM_FN];
  logic [NUM_FN-1:0] fn_en;
  logic [NUM_FN-1:0] fn_hit;
  logic [NUM_FN-1:0] fn_req;
  logic [NUM_FN-1:0] fn_gnt;

  lio_cfg_regs #(.ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_valid (io_valid),
    .io_write (io_write),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .index_q  (index_q),
    .regs_q   (regs_q),
    .rdata    (io_rdata),
    .cfg_hit  (cfg_hit)
  );

  lio_base_map #(.ADDR_W(ADDR_W)) u_map (
    .regs (regs_q),
    .base (fn_base),
    .en   (fn_en)
  );

  for (genvar g = 0; g < NUM_FN; g++) begin : g_win
    lio_window #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_win (
      .enable (fn_en[g]),
      .base   (fn_base[g]),
      .addr   (io_addr),
      .hit    (fn_hit[g])
    );
    assign fn_req[g] = io_valid && fn_hit[g];
  end

  lio_prio #(.N(NUM_FN)) u_prio (
    .block (cfg_hit),
    .req   (fn_req),
    .gnt   (fn_gnt)
  );

  assign sel_cfg = cfg_hit;
  assign sel_sp1 = fn_gnt[FN_SP1];
  assign sel_sp2 = fn_gnt[FN_SP2];
  assign sel_lpt = fn_gnt[FN_LPT];
  assign sel_fdc = fn_gnt[FN_FDC];
endmodule

// File: rtl/lio_checker.sv
module lio_checker
  import lio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h03F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_valid,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_rdata,
  input logic              sel_cfg,
  input logic              sel_sp1,
  input logic              sel_sp2,
  input logic              sel_lpt,
  input logic              sel_fdc,
  input logic [7:0]        index_q,
  input cfg_regs_t         regs_q
);
  logic on_pair;
  logic any_fn;
  assign on_pair = (io_addr == CFG_PORT) || (io_addr == CFG_PORT + 1'b1);
  assign any_fn  = sel_sp1 || sel_sp2 || sel_lpt || sel_fdc;

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cfg, sel_sp1, sel_sp2, sel_lpt, sel_fdc}));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !(sel_cfg || any_fn));

  a_r1_pair_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && on_pair) |-> (sel_cfg && !any_fn));

  a_r4_fdc_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fdc |-> regs_q.fsel[4]);

  a_r4_serial_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sp1 |-> regs_q.fsel[2]) and (sel_sp2 |-> regs_q.fsel[3]));

  a_r5_lpt_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lpt |-> (regs_q.fsel[1:0] != 2'b11));

  a_r9_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && io_addr == CFG_PORT + 1'b1 && index_q >= 8'hFD)
      |=> $stable(regs_q));

  a_r2_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && !io_write && on_pair) |-> (io_rdata == 8'h00));
endmodule

bind legacy_io_router lio_checker #(.ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_valid (io_valid),
  .io_write (io_write),
  .io_addr  (io_addr),
  .io_rdata (io_rdata),
  .sel_cfg  (sel_cfg),
  .sel_sp1  (sel_sp1),
  .sel_sp2  (sel_sp2),
  .sel_lpt  (sel_lpt),
  .sel_fdc  (sel_fdc),
  .index_q  (index_q),
  .regs_q   (regs_q)
);

// File: tb/legacy_io_router_tb.sv
`timescale 1ns/1ps
module legacy_io_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        sel_cfg, sel_sp1, sel_sp2, sel_lpt, sel_fdc;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // select vector order: {cfg, sp1, sp2, lpt, fdc}
  localparam logic [4:0] S_NONE = 5'b00000, S_CFG = 5'b10000, S_SP1 = 5'b01000,
                         S_SP2 = 5'b00100, S_LPT = 5'b00010, S_FDC = 5'b00001;

  always #2.5 clk = ~clk;

  legacy_io_router u_dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sel_cfg(sel_cfg), .sel_sp1(sel_sp1), .sel_sp2(sel_sp2),
    .sel_lpt(sel_lpt), .sel_fdc(sel_fdc)
  );

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // one bus cycle; outputs sampled 1 ns after the falling edge
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic [4:0] sels);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_wdata = d;
    #1;
    rd   = io_rdata;
    sels = {sel_cfg, sel_sp1, sel_sp2, sel_lpt, sel_fdc};
    @(posedge clk);
    #1 io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] val);
    logic [7:0] rd; logic [4:0] s;
    access(1'b1, 16'h03F0, idx, rd, s);
    access(1'b1, 16'h03F1, val, rd, s);
  endtask

  task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] val);
    logic [7:0] rd; logic [4:0] s;
    access(1'b1, 16'h03F0, idx, rd, s);
    access(1'b0, 16'h03F1, 8'h00, val, s);
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic [4:0] exp);
    logic [7:0] rd; logic [4:0] s;
    access(1'b0, a, 8'h00, rd, s);
    check(req, int'(s), int'(exp));
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cfg_rd(8'hE0, v); check("R3 devid", v, 8'h3C);
    cfg_rd(8'hE2, v); check("R3 fsel", v, 8'h0F);
    cfg_rd(8'hE3, v); check("R3 fdc reg", v, 8'hFC);
    cfg_rd(8'hE6, v); check("R3 lpt reg", v, 8'hDE);
    cfg_rd(8'hE7, v); check("R3 sp1 reg", v, 8'hFE);
    cfg_rd(8'hE8, v); check("R3 sp2 reg", v, 8'hBE);
    probe("R3 sp1 at 3F8", 16'h03F8, S_SP1);
    probe("R3 sp2 at 2FF", 16'h02FF, S_SP2);
    probe("R3 lpt off", 16'h0378, S_NONE);
    probe("R3 fdc off", 16'h03F4, S_NONE);
  endtask

  task automatic t_index_port;
    logic [7:0] rd; logic [4:0] s;
    access(1'b1, 16'h03F0, 8'hE6, rd, s);
    check("R1 index write claims cfg", s, S_CFG);
    access(1'b0, 16'h03F0, 8'h00, rd, s);
    check("R1 index readback", rd, 8'hE6);
    check("R1 index read claims cfg", s, S_CFG);
    cfg_rd(8'hE5, rd); check("R2 unmapped reads zero", rd, 8'h00);
    access(1'b0, 16'h0100, 8'h00, rd, s);
    check("R2 rdata zero off pair", rd, 8'h00);
    check("R11 no window matches", s, S_NONE);
  endtask

  task automatic t_enable_floppy;
    logic [7:0] rd; logic [4:0] s;
    cfg_wr(8'hE2, 8'h14);            // floppy + sp1, parallel mode 0
    probe("R4 fdc on at 3F4", 16'h03F4, S_FDC);
    probe("R1 pair beats fdc 3F0", 16'h03F0, S_CFG);
    probe("R1 pair beats fdc 3F1", 16'h03F1, S_CFG);
    probe("R5 lpt mode0 on", 16'h0378, S_LPT);
    probe("R4 sp2 off", 16'h02F8, S_NONE);
    @(negedge clk); io_addr = 16'h03F8; io_valid = 1'b0; #1;
    check("R11 idle no select", {sel_cfg, sel_sp1, sel_sp2, sel_lpt, sel_fdc}, S_NONE);
    access(1'b0, 16'h03F8, 8'h00, rd, s);
    check("R4 sp1 on", s, S_SP1);
  endtask

  task automatic t_lpt_modes;
    cfg_wr(8'hE2, 8'h01); probe("R5 mode1 on", 16'h037F, S_LPT);
    cfg_wr(8'hE2, 8'h02); probe("R5 mode2 on", 16'h0378, S_LPT);
    cfg_wr(8'hE2, 8'h03); probe("R5 mode3 off", 16'h0378, S_NONE);
  endtask

  task automatic t_relocate;
    cfg_wr(8'hE2, 8'h10);
    cfg_wr(8'hE3, 8'hFF);            // low two bits masked: base 0x3F0
    probe("R6 fdc masked base", 16'h03F7, S_FDC);
    cfg_wr(8'hE3, 8'h5D);            // 0x5C<<2 = 0x170
    probe("R6 fdc moved 170", 16'h0170, S_FDC);
    probe("R6 fdc left 3F4", 16'h03F4, S_NONE);
    cfg_wr(8'hE2, 8'h00);            // parallel only
    cfg_wr(8'hE6, 8'hEF);            // base 0x3BC
    probe("R7 lpt low edge", 16'h03BC, S_LPT);
    probe("R7 lpt high edge", 16'h03C3, S_LPT);
    probe("R7 lpt below", 16'h03BB, S_NONE);
    probe("R7 lpt above", 16'h03C4, S_NONE);
    cfg_wr(8'hE2, 8'h0F);
    cfg_wr(8'hE7, 8'h5F);            // bit0 masked: 0x5E<<2 = 0x178
    probe("R8 sp1 masked base", 16'h0178, S_SP1);
    probe("R8 sp1 window end", 16'h017F, S_SP1);
    cfg_wr(8'hE8, 8'h21);            // 0x20<<2 = 0x080
    probe("R8 sp2 moved", 16'h0087, S_SP2);
  endtask

  task automatic t_priority;
    cfg_wr(8'hE2, 8'h1C);            // all on, parallel mode 0
    cfg_wr(8'hE6, 8'hDE);            // 0x378
    cfg_wr(8'hE8, 8'hDE);            // sp2 also 0x378
    probe("R11 sp2 over lpt", 16'h0378, S_SP2);
    cfg_wr(8'hE7, 8'hDE);            // sp1 also 0x378
    probe("R11 sp1 over sp2", 16'h0378, S_SP1);
    cfg_wr(8'hE3, 8'hDE);            // fdc base 0x370, overlaps 0x370-0x377
    cfg_wr(8'hE6, 8'hDC);            // lpt 0x370
    probe("R11 lpt over fdc", 16'h0372, S_LPT);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    cfg_wr(8'hFD, 8'h55); cfg_rd(8'hFD, v); check("R9 FD ignored", v, 8'h00);
    cfg_wr(8'hFF, 8'hAA); cfg_rd(8'hFF, v); check("R9 FF ignored", v, 8'h00);
    cfg_wr(8'hE0, 8'h11); cfg_rd(8'hE0, v); check("R9 devid kept", v, 8'h3C);
    cfg_wr(8'hE4, 8'h77); cfg_rd(8'hE4, v); check("R9 unmapped ignored", v, 8'h00);
    cfg_rd(8'hE2, v); check("R9 fsel untouched", v, 8'h1C);
  endtask

  task automatic t_immediate;
    logic [7:0] rd; logic [4:0] s;
    cfg_wr(8'hE2, 8'h04);
    cfg_wr(8'hE7, 8'hFE);            // sp1 back to 0x3F8
    access(1'b1, 16'h03F0, 8'hE7, rd, s);
    access(1'b1, 16'h03F1, 8'hBE, rd, s);   // moves sp1 to 0x2F8
    access(1'b0, 16'h02F8, 8'h00, rd, s);   // very next cycle
    check("R10 next cycle uses new base", s, S_SP1);
    access(1'b1, 16'h03F0, 8'hE2, rd, s);
    access(1'b1, 16'h03F1, 8'h00, rd, s);   // disable sp1
    access(1'b0, 16'h02F8, 8'h00, rd, s);
    check("R10 next cycle uses new enable", s, S_NONE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_index_port();
    t_enable_floppy();
    t_lpt_modes();
    t_relocate();
    t_priority();
    t_readonly();
    t_immediate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule